// File: doc/BRIEF.md
# APB Level Interrupt Aggregator

The block gathers a build-time number of level-sensitive interrupt lines (anywhere from 2 to 64) behind an APB slave port. It folds them into one interrupt request for a processor or a parent controller. Each line has its own enable bit and its own mask bit. The block computes a per-line final status that software scans to find which lines are pending. The logic is spread across two 32-bit words: lines 0–31 in the low word and lines 32–63 in the high word.

Enable and mask bits exist only for the lines that are built. Software learns the line count by writing all ones to both enable words and reading them back: bits above the count read as zero. The incoming lines are retimed through a two-stage synchronizer. The combined request is a registered OR of all final-status bits. Status is purely level-driven and needs no clearing by software.

Top module: `apb_irq_aggregator`

## Requirements
- R1: After reset, every enable and mask bit is 0, every status bit reads 0, and `irq_o` is low.
- R2: The enable words sit at byte offsets 0x00 (lines 0–31) and 0x04 (lines 32–63). The mask words sit at 0x08 and 0x0C. The final-status words sit at 0x30 and 0x34. Register bit k of a word maps to line k of that word. The enable and mask words are read/write.
- R3: Enable and mask bits for lines at or above the configured count `N_SRC` read as 0, even after 1s are written to them. With `N_SRC` = 40, writing all ones reads back 0xFFFFFFFF from the low word and 0x000000FF from the high word. When `N_SRC` ≤ 32, the high words read 0 and ignore writes.
- R4: A final-status bit reads 1 exactly when its synchronized line is high, its enable bit is 1 and its mask bit is 0.
- R5: A status bit follows its line's level: it clears on its own once the line falls. Writes to the status words change nothing.
- R6: `irq_o` is the OR of all final-status bits, registered once. A line change reaches the readable status after two rising clock edges and reaches `irq_o` after three.
- R7: Reads of any other offset return 0, and writes to any other offset change no state. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready, no wait states |
| pslverr | output | 1 | Always 0 |
| src_i | input | N_SRC | Level-sensitive interrupt lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted enable or mask bit shows up on the next read of its word. It also shows up in the status word and on `irq_o` within three clock edges, once the matching line is driven. A synchronizer stage that is missing or extra shifts when `irq_o` rises by one cycle, so the bench samples the request at the exact edge count. Bits that should not exist would appear as nonzero upper bits in the high enable word read-back.

// File: rtl/apb_irq_aggregator.sv
module apb_irq_aggregator #(
  parameter int N_SRC = 40,
  parameter int AW    = 8
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o
);

  localparam logic [AW-1:0] OFF_EN_LO = AW'(8'h00);
  localparam logic [AW-1:0] OFF_EN_HI = AW'(8'h04);
  localparam logic [AW-1:0] OFF_MK_LO = AW'(8'h08);
  localparam logic [AW-1:0] OFF_MK_HI = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_ST_LO = AW'(8'h30);
  localparam logic [AW-1:0] OFF_ST_HI = AW'(8'h34);
  localparam logic [63:0]   IMPL      = (N_SRC >= 64) ? {64{1'b1}} : ((64'd1 << N_SRC) - 64'd1);

  logic [N_SRC-1:0] en_q, mk_q, s1_q, s2_q, stat;
  logic [63:0]      en_x, mk_x, st_x;
  logic             wr;

  assign wr      = psel & penable & pwrite;
  assign stat    = s2_q & en_q & ~mk_q;
  assign en_x    = 64'(en_q);
  assign mk_x    = 64'(mk_q);
  assign st_x    = 64'(stat);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q <= '0;
      mk_q <= '0;
    end else if (wr) begin
      case (paddr)
        OFF_EN_LO: en_q <= N_SRC'({en_x[63:32], pwdata});
        OFF_EN_HI: en_q <= N_SRC'({pwdata, en_x[31:0]});
        OFF_MK_LO: mk_q <= N_SRC'({mk_x[63:32], pwdata});
        OFF_MK_HI: mk_q <= N_SRC'({pwdata, mk_x[31:0]});
        default: ;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      s1_q  <= '0;
      s2_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      s1_q  <= src_i;
      s2_q  <= s1_q;
      irq_o <= |stat;
    end
  end

  always_comb begin
    case (paddr)
      OFF_EN_LO: prdata = en_x[31:0];
      OFF_EN_HI: prdata = en_x[63:32];
      OFF_MK_LO: prdata = mk_x[31:0];
      OFF_MK_HI: prdata = mk_x[63:32];
      OFF_ST_LO: prdata = st_x[31:0];
      OFF_ST_HI: prdata = st_x[63:32];
      default:   prdata = 32'h0;
    endcase
  end

  AST_UNIMPL_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (paddr == OFF_EN_HI || paddr == OFF_MK_HI) |-> ((prdata & ~IMPL[63:32]) == 32'h0)); // R3
  AST_UNDEF_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (paddr != OFF_EN_LO && paddr != OFF_EN_HI && paddr != OFF_MK_LO &&
     paddr != OFF_MK_HI && paddr != OFF_ST_LO && paddr != OFF_ST_HI) |-> (prdata == 32'h0)); // R7
  AST_LEVEL_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    (s2_q == '0) |=> !irq_o); // R5
  AST_MASKED_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    (&mk_q) |=> !irq_o); // R4
  AST_NEEDS_ENABLE: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq_o) |-> $past(|en_q)); // R6

endmodule

// File: tb/apb_irq_aggregator_tb.sv
module apb_irq_aggregator_tb_top;
  localparam int N = 40;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr, irq_o;
  logic [N-1:0] src = '0;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] a; logic [31:0] exp; string req; } item_t;
  item_t sbq[$];

  always #2 pclk = ~pclk;

  apb_irq_aggregator #(.N_SRC(N), .AW(8)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .src_i(src), .irq_o(irq_o));

  always @(negedge pclk) begin
    #1;
    if (psel && penable && !pwrite && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      total++;
      if (prdata !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.a, prdata, it.exp);
      end
      total++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
        bad++;
        $display("FAIL R7 handshake actual=%b%b expected=10", pready, pslverr);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.a = a; it.exp = e; it.req = req;
    sbq.push_back(it);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    #1;
    total++;
    if (irq_o !== e) begin
      bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, irq_o, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge pclk);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk); chk_irq(0, "R1");
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1");
    rd(8'h0C, 0, "R1"); rd(8'h30, 0, "R1"); rd(8'h34, 0, "R1");

    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_FFFF, "R2"); rd(8'h04, 32'h0000_00FF, "R3");
    wr(8'h08, 32'hA5A5_A5A5); wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, 32'hA5A5_A5A5, "R2"); rd(8'h0C, 32'h0000_00FF, "R3");
    wr(8'h08, 0); wr(8'h0C, 0);

    src = 40'h12_8000_0001; settle();
    rd(8'h30, 32'h8000_0001, "R4"); rd(8'h34, 32'h0000_0012, "R4");
    chk_irq(1, "R6");
    wr(8'h08, 32'h1);
    rd(8'h30, 32'h8000_0000, "R4");
    wr(8'h04, 32'h0000_00FD);
    rd(8'h34, 32'h0000_0010, "R4");

    wr(8'h30, 32'h0); wr(8'h34, 32'h0);
    rd(8'h30, 32'h8000_0000, "R5"); rd(8'h34, 32'h0000_0010, "R5");

    wr(8'h10, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h10, 0, "R7"); rd(8'h3C, 0, "R7"); rd(8'h20, 0, "R7");
    rd(8'h00, 32'hFFFF_FFFF, "R7"); rd(8'h08, 32'h1, "R7");

    @(negedge pclk); src = '0;
    repeat (2) @(negedge pclk); chk_irq(1, "R6");
    @(negedge pclk); chk_irq(0, "R6");
    rd(8'h30, 0, "R5"); rd(8'h34, 0, "R5");

    @(negedge pclk); src = 40'h00_0000_0100;
    repeat (2) @(negedge pclk); chk_irq(0, "R6");
    @(negedge pclk); chk_irq(1, "R6");
    rd(8'h30, 32'h0000_0100, "R4");

    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    src = '1; settle();
    chk_irq(0, "R4");
    rd(8'h30, 0, "R4"); rd(8'h34, 0, "R4");

    repeat (3) @(negedge pclk);
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R2 pending reads actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule